// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver with Character Queue

This block turns a single asynchronous serial input line into parallel characters. Software selects the format through static configuration pins: a data field of five to eight bits, a parity mode (none, even, odd, or a parity bit that must hold a fixed level) and a 16-bit bit-period divider. The receiver oversamples the line 32 times per bit. It confirms a start bit at its centre and samples every later bit at its centre, with the least significant bit first.

Each finished character enters a four-entry queue together with its own parity-error and framing-error flags. The oldest entry is always shown on the read port with its flags, and a one-cycle read strobe removes it. Level outputs report whether data is waiting and whether the queue is full. A sticky overrun flag records a character that was lost because the queue was full. The flow-control output is high while there is room for more data.

A separate watcher measures how long the line stays low. It reports the start of a break and the end of a break as single-cycle events, and a level output shows that a break is in progress. A break is found even when the low level begins partway through a character.

Top module: `async_rx_core`

## Requirements
- R1: One bit lasts 32 × `cfg_div` clock cycles, and a divider of 0 acts as 1. A falling edge starts a character only if the line is still low 16 oversample ticks later. A low pulse shorter than half a bit produces no character.
- R2: `cfg_len` = 0,1,2,3 selects 5,6,7,8 data bits. Bits arrive least significant first, and unused upper bits of `rd_data` read 0.
- R3: `cfg_par` encodes 0 = none, 1 = even, 2 = odd, 3 = parity bit must be 0, 4 = parity bit must be 1. When the mode is not none, a parity bit follows the data. `rd_perr` is 1 for a character whose parity bit differs from the expected value: for even, the XOR of the data bits; for odd, its inverse; for the fixed modes, the fixed level.
- R4: Only the first stop bit is checked. If it is sampled low, the character is still stored with `rd_ferr` = 1, and no new start is accepted until the line has returned high.
- R5: Characters leave the queue in arrival order. `rd_data`, `rd_perr` and `rd_ferr` show the oldest entry, and `rd_en` high for one cycle while data is waiting removes it.
- R6: `rx_ready` is 1 whenever at least one character is held. `fifo_full` is 1 exactly when all 4 entries are held.
- R7: `rts` is 1 while fewer than 3 characters are held (one entry kept in reserve) and 0 otherwise.
- R8: A character that completes while the queue is full is discarded. `overrun` then goes to 1 and stays 1 until a one-cycle `clr_err` pulse.
- R9: `break_start` pulses once, and `break_active` rises, when the line has been low for one full character time: (7 + `cfg_len` + parity present) bits. This includes a low level that begins in the middle of a character. An all-zero character with a high stop bit is not a break.
- R10: When the line returns high during a break, `break_end` pulses once and `break_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data length select (5 + value bits) |
| cfg_par | input | 3 | Parity mode select |
| cfg_div | input | 16 | Oversample divider |
| rd_en | input | 1 | Remove the oldest character |
| clr_err | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| rx_ready | output | 1 | At least one character is waiting |
| fifo_full | output | 1 | All queue entries are held |
| overrun | output | 1 | Sticky lost-character flag |
| rts | output | 1 | Room to accept data |
| break_start | output | 1 | One-cycle pulse when a break is detected |
| break_end | output | 1 | One-cycle pulse when a break ends |
| break_active | output | 1 | A break is in progress |

## Verification
The bench checks a break that begins after three high data bits. A design that armed its break timer only at a start edge would never report this break, and a design that shared the framing counter would report it late or twice. It also sends an all-zero character with a high stop bit, which a threshold one bit too short would mistake for a break. Four characters are queued without reads and then a fifth arrives: a wrong accept rule would overwrite the oldest entry or keep the new one, and a non-sticky overrun would clear itself on the next read. Wrong parity bits are sent in every parity mode, and a glitch shorter than half a bit is sent to show that no character is made from it.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int OVS = 32;

    typedef enum logic [2:0] {
        PAR_NONE   = 3'd0,
        PAR_EVEN   = 3'd1,
        PAR_ODD    = 3'd2,
        PAR_FIXED0 = 3'd3,
        PAR_FIXED1 = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP,
        FS_HOLD
    } frame_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_state_t;

    tick_state_t s_d, s_q;
    logic [DIV_W-1:0] lim_d;

    always_comb begin
        s_d      = s_q;
        lim_d    = (div == '0) ? DIV_W'(1) : div;
        s_d.tick = 1'b0;
        if (s_q.cnt >= lim_d - DIV_W'(1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> !tick); // R1

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import async_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    output logic       push,
    output rx_char_t   push_char
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    typedef struct packed {
        frame_st_e       st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]      idx;
        logic [7:0]      shreg;
        logic            par_bit;
        logic            push;
        rx_char_t        chr;
    } eng_state_t;

    eng_state_t s_d, s_q;
    par_mode_e  mode_d;
    logic [2:0] last_idx_d;
    logic       exp_par_d;

    always_comb begin
        s_d        = s_q;
        s_d.push   = 1'b0;
        mode_d     = par_mode_e'(cfg_par);
        last_idx_d = {1'b0, cfg_len} + 3'd4;
        case (mode_d)
            PAR_EVEN:   exp_par_d = ^s_q.shreg;
            PAR_ODD:    exp_par_d = ~^s_q.shreg;
            PAR_FIXED1: exp_par_d = 1'b1;
            default:    exp_par_d = 1'b0;
        endcase
        case (s_q.st)
            FS_IDLE: begin
                if (tick && !line) begin
                    s_d.st  = FS_START;
                    s_d.cnt = '0;
                end
            end
            FS_START: begin
                if (tick) begin
                    if (s_q.cnt == MID) begin
                        s_d.cnt   = '0;
                        s_d.idx   = '0;
                        s_d.shreg = '0;
                        s_d.st    = line ? FS_IDLE : FS_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            FS_DATA: begin
                if (tick) begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt              = '0;
                        s_d.shreg[s_q.idx]   = line;
                        if (s_q.idx == last_idx_d)
                            s_d.st = (mode_d == PAR_NONE) ? FS_STOP : FS_PAR;
                        else
                            s_d.idx = s_q.idx + 3'd1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            FS_PAR: begin
                if (tick) begin
                    if (s_q.cnt == LAST) begin
                        s_d.cnt     = '0;
                        s_d.par_bit = line;
                        s_d.st      = FS_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            FS_STOP: begin
                if (tick) begin
                    if (s_q.cnt == LAST) begin
                        s_d.push     = 1'b1;
                        s_d.chr.data = s_q.shreg;
                        s_d.chr.ferr = !line;
                        s_d.chr.perr = (mode_d != PAR_NONE) &&
                                       (s_q.par_bit != exp_par_d);
                        s_d.st       = line ? FS_IDLE : FS_HOLD;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            FS_HOLD: begin
                if (line) s_d.st = FS_IDLE;
            end
            default: s_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: FS_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign push      = s_q.push;
    assign push_char = s_q.chr;

    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R1
    AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == FS_IDLE && s_d.st == FS_START) |-> !line); // R1

endmodule

// File: rtl/rx_break_watch.sv
module rx_break_watch
    import async_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    output logic       brk_start,
    output logic       brk_end,
    output logic       brk_active
);
    localparam int BRK_W = $clog2(12 * OVS + 1);

    typedef struct packed {
        logic [BRK_W-1:0] cnt;
        logic             active;
        logic             start;
        logic             stop;
    } brk_state_t;

    brk_state_t       s_d, s_q;
    logic [BRK_W-1:0] thr_d;
    logic             par_on_d;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.stop  = 1'b0;
        par_on_d  = (cfg_par != 3'd0);
        thr_d     = BRK_W'((32'd7 + {30'd0, cfg_len} + {31'd0, par_on_d}) * OVS);
        if (line) begin
            s_d.cnt = '0;
            if (s_q.active) begin
                s_d.active = 1'b0;
                s_d.stop   = 1'b1;
            end
        end else if (tick && !s_q.active) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt + 1'b1 >= thr_d) begin
                s_d.active = 1'b1;
                s_d.start  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign brk_start  = s_q.start;
    assign brk_end    = s_q.stop;
    assign brk_active = s_q.active;

    AST_BRK_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_start && brk_end)); // R9
    AST_BRK_END_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> ($past(brk_active) && !brk_active)); // R10

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import async_rx_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int MARGIN = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_char_t push_char,
    input  logic     pop,
    input  logic     clr_err,
    output rx_char_t head,
    output logic     not_empty,
    output logic     full,
    output logic     ovr,
    output logic     room
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_RTS  = CNT_W'(DEPTH - MARGIN);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wp;
        logic [PTR_W-1:0]     rp;
        logic [CNT_W-1:0]     cnt;
        logic                 ovr;
    } q_state_t;

    q_state_t s_d, s_q;
    logic do_pop_d, do_push_d;

    always_comb begin
        s_d       = s_q;
        do_pop_d  = pop && (s_q.cnt != '0);
        do_push_d = push && ((s_q.cnt != CNT_FULL) || do_pop_d);
        if (do_push_d) begin
            s_d.mem[s_q.wp] = push_char;
            s_d.wp = (s_q.wp == PTR_LAST) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop_d)
            s_d.rp = (s_q.rp == PTR_LAST) ? '0 : s_q.rp + 1'b1;
        case ({do_push_d, do_pop_d})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (clr_err)
            s_d.ovr = 1'b0;
        else if (push && !do_push_d)
            s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head      = s_q.mem[s_q.rp];
    assign not_empty = (s_q.cnt != '0);
    assign full      = (s_q.cnt == CNT_FULL);
    assign ovr       = s_q.ovr;
    assign room      = (s_q.cnt < CNT_RTS);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_FULL); // R6
    AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> not_empty); // R6
    AST_RTS_OFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !room); // R7
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr_err) |=> ovr); // R8

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int RTS_MARGIN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [1:0]       cfg_len,
    input  logic [2:0]       cfg_par,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             rd_en,
    input  logic             clr_err,
    output logic [7:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             rx_ready,
    output logic             fifo_full,
    output logic             overrun,
    output logic             rts,
    output logic             break_start,
    output logic             break_end,
    output logic             break_active
);
    typedef struct packed {
        logic meta;
        logic line;
    } sync_state_t;

    sync_state_t sy_d, sy_q;
    logic        tick_w;
    logic        push_w;
    rx_char_t    push_char_w;
    rx_char_t    head_w;

    always_comb begin
        sy_d.meta = rxd;
        sy_d.line = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{meta: 1'b1, line: 1'b1};
        else        sy_q <= sy_d;
    end

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .tick  (tick_w)
    );

    rx_frame_engine u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .line      (sy_q.line),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .push      (push_w),
        .push_char (push_char_w)
    );

    rx_break_watch u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .line       (sy_q.line),
        .cfg_len    (cfg_len),
        .cfg_par    (cfg_par),
        .brk_start  (break_start),
        .brk_end    (break_end),
        .brk_active (break_active)
    );

    rx_char_queue #(.DEPTH(FIFO_DEPTH), .MARGIN(RTS_MARGIN)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .push_char (push_char_w),
        .pop       (rd_en),
        .clr_err   (clr_err),
        .head      (head_w),
        .not_empty (rx_ready),
        .full      (fifo_full),
        .ovr       (overrun),
        .room      (rts)
    );

    assign rd_data = head_w.data;
    assign rd_perr = head_w.perr;
    assign rd_ferr = head_w.ferr;

    AST_PUSH_ONLY_WITH_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_w && fifo_full && !rd_en && !clr_err) |=> overrun); // R8

endmodule

// File: tb/async_rx_core_test.sv
module async_rx_core_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  cfg_len = 2'd3;
    logic [2:0]  cfg_par = 3'd0;
    logic [15:0] cfg_div = 16'd2;
    logic        rd_en = 1'b0;
    logic        clr_err = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_perr, rd_ferr, rx_ready, fifo_full, overrun, rts;
    logic        break_start, break_end, break_active;

    int   checks = 0;
    int   errors = 0;
    bit   check_en = 1'b0;
    bit   exp_ovr = 1'b0;
    bit   done = 1'b0;
    int   n_bs = 0;
    int   n_be = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_rx_core uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_div(cfg_div), .rd_en(rd_en),
        .clr_err(clr_err), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .overrun(overrun), .rts(rts), .break_start(break_start),
        .break_end(break_end), .break_active(break_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && break_start) n_bs++;
        if (rst_n && break_end)   n_be++;
    end

    // reference model compared on every clock while the line is quiet
    always @(negedge clk) begin
        if (check_en && !done) begin
            check(rx_ready == (q.size() > 0), "R6", "rx_ready", rx_ready, q.size() > 0);
            check(fifo_full == (q.size() == 4), "R6", "fifo_full", fifo_full, q.size() == 4);
            check(rts == (q.size() < 3), "R7", "rts", rts, q.size() < 3);
            check(overrun == exp_ovr, "R8", "overrun", overrun, exp_ovr);
            if (q.size() > 0) begin
                check(rd_data == q[0].data, "R5", "rd_data", rd_data, q[0].data);
                check(rd_perr == q[0].perr, "R3", "rd_perr", rd_perr, q[0].perr);
                check(rd_ferr == q[0].ferr, "R4", "rd_ferr", rd_ferr, q[0].ferr);
            end
        end
    end

    function automatic int bit_clks();
        return 32 * ((cfg_div == 16'd0) ? 1 : int'(cfg_div));
    endfunction

    function automatic logic exp_parity(input logic [7:0] d, input int pm);
        case (pm)
            1: return ^d;
            2: return ~^d;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic hold_line(input logic v, input int bits);
        rxd = v;
        repeat (bits * bit_clks()) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
        int    len;
        int    pm;
        logic  pb;
        logic [7:0] dm;
        exp_t  e;
        len = 5 + int'(cfg_len);
        pm  = int'(cfg_par);
        dm  = d & 8'((1 << len) - 1);
        check_en = 1'b0;
        hold_line(1'b0, 1);
        for (int i = 0; i < len; i++) hold_line(dm[i], 1);
        pb = exp_parity(dm, pm) ^ bad_par;
        if (pm != 0) hold_line(pb, 1);
        hold_line(stop_v, 1);
        e.data = dm;
        e.perr = (pm != 0) && bad_par;
        e.ferr = !stop_v;
        if (q.size() < 4) q.push_back(e);
        else exp_ovr = 1'b1;
        hold_line(1'b1, 1);
        check_en = 1'b1;
    endtask

    task automatic pop_one(input string req);
        check_en = 1'b0;
        @(negedge clk);
        check(rx_ready == 1'b1, req, "ready before read", rx_ready, 1);
        check(rd_data == q[0].data, req, "popped data", rd_data, q[0].data);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        void'(q.pop_front());
        check_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(rx_ready == 1'b0 && fifo_full == 1'b0, "R6", "reset levels",
              {rx_ready, fifo_full}, 0);
        check(rts == 1'b1, "R7", "reset rts", rts, 1);
        check(overrun == 1'b0 && break_active == 1'b0, "R8", "reset flags",
              {overrun, break_active}, 0);
        check_en = 1'b1;
        hold_line(1'b1, 2);

        // R2: 8 bits, no parity, LSB first
        cfg_len = 2'd3; cfg_par = 3'd0;
        send(8'hA5, 1'b0, 1'b1);
        send(8'h3C, 1'b0, 1'b1);
        pop_one("R5"); pop_one("R5");

        // R2 R3: 5-bit even parity, good then bad
        cfg_len = 2'd0; cfg_par = 3'd1;
        send(8'h15, 1'b0, 1'b1);
        send(8'h0B, 1'b1, 1'b1);
        pop_one("R3"); pop_one("R3");

        // R3: 7-bit odd, fixed-one and fixed-zero modes
        cfg_len = 2'd2; cfg_par = 3'd2;
        send(8'h5A, 1'b0, 1'b1);
        send(8'h11, 1'b1, 1'b1);
        cfg_len = 2'd1; cfg_par = 3'd4;
        send(8'h2E, 1'b0, 1'b1);
        send(8'h01, 1'b1, 1'b1);
        pop_one("R3"); pop_one("R3"); pop_one("R3"); pop_one("R3");
        cfg_par = 3'd3;
        send(8'h3F, 1'b1, 1'b1);
        send(8'h20, 1'b0, 1'b1);
        pop_one("R3"); pop_one("R3");

        // R4: framing error, line held low one extra bit before idle
        cfg_len = 2'd3; cfg_par = 3'd0;
        send(8'hC3, 1'b0, 1'b0);
        pop_one("R4");

        // R1: short glitch gives no character; other divider values
        check_en = 1'b0;
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        hold_line(1'b1, 3);
        check_en = 1'b1;
        @(negedge clk);
        check(rx_ready == 1'b0, "R1", "glitch produced char", rx_ready, 0);
        cfg_div = 16'd3;
        send(8'h96, 1'b0, 1'b1);
        cfg_div = 16'd0;
        hold_line(1'b1, 1);
        send(8'h4D, 1'b0, 1'b1);
        pop_one("R1"); pop_one("R1");
        cfg_div = 16'd2;
        hold_line(1'b1, 2);

        // R6 R7 R8: fill, overflow, drain, clear
        send(8'h01, 1'b0, 1'b1);
        send(8'h02, 1'b0, 1'b1);
        send(8'h03, 1'b0, 1'b1);
        check(rts == 1'b0, "R7", "rts with 3 held", rts, 0);
        send(8'h04, 1'b0, 1'b1);
        check(fifo_full == 1'b1, "R6", "full with 4", fifo_full, 1);
        send(8'h05, 1'b0, 1'b1);
        check(overrun == 1'b1, "R8", "overrun after 5th", overrun, 1);
        pop_one("R8"); pop_one("R8"); pop_one("R8"); pop_one("R8");
        check(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
        check_en = 1'b0;
        @(negedge clk);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        exp_ovr = 1'b0;
        check_en = 1'b1;
        @(negedge clk);
        check(overrun == 1'b0, "R8", "overrun cleared", overrun, 0);

        // R9: all-zero character is not a break
        send(8'h00, 1'b0, 1'b1);
        check(n_bs == 0, "R9", "zero char broke", n_bs, 0);
        pop_one("R9");

        // R9 R10: break that begins after three high data bits
        check_en = 1'b0;
        hold_line(1'b0, 1);
        hold_line(1'b1, 3);
        hold_line(1'b0, 12);
        check(n_bs == 1, "R9", "mid-char break start", n_bs, 1);
        check(break_active == 1'b1, "R9", "break level", break_active, 1);
        check(n_be == 0, "R10", "early break end", n_be, 0);
        begin
            exp_t e;
            e.data = 8'h07; e.perr = 1'b0; e.ferr = 1'b1;
            q.push_back(e);
        end
        hold_line(1'b1, 2);
        check(n_be == 1, "R10", "break end pulse", n_be, 1);
        check(break_active == 1'b0, "R10", "break level after", break_active, 0);
        check(n_bs == 1, "R9", "single break start", n_bs, 1);
        check_en = 1'b1;
        pop_one("R4");
        hold_line(1'b1, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule